// File: doc/BRIEF.md
# SPI Serial EEPROM Target Core

This block models the target side of a byte-organised serial EEPROM. It runs on a fast system clock and oversamples the serial pins: SCK, data in, and an active-low chip select. It returns serial data on an output that has its own enable, so the output can be high impedance. SPI modes 0 and 3 are both accepted. Each command starts with an 8-bit opcode, sent MSB first. Array commands then carry a 16-bit address. Reads stream bytes one after another from an on-chip byte array.

Writes are collected in a page buffer. When chip select rises at a byte boundary, the buffered bytes are committed to the array during a busy interval of fixed length. During that interval a page walker copies the marked bytes into the array. Write-enable and block-protection decisions belong to a separate protection unit. That unit grants or withholds each commit through a permit input, and it supplies the upper status bits for the status read.

FSM states:
- `ST_IDLE`: deselected.
- `ST_OPCODE`: shifting the opcode.
- `ST_ADDR`: shifting the address.
- `ST_RD_DATA`: streaming array bytes.
- `ST_WR_DATA`: collecting page bytes.
- `ST_STATUS`: streaming the status byte.
- `ST_SINK`: an ignored command, held until deselect.

Transitions:
- `ST_IDLE` to `ST_OPCODE` on a chip-select fall.
- `ST_OPCODE` to `ST_ADDR` on a READ or WRITE opcode while not busy.
- `ST_OPCODE` to `ST_STATUS` on a status-read opcode.
- `ST_OPCODE` to `ST_SINK` on any other opcode, or on READ or WRITE while busy.
- `ST_ADDR` to `ST_RD_DATA` or `ST_WR_DATA` after the 16th address bit.
- Every state returns to `ST_IDLE` on a chip-select rise.

Top module: `spi_eeprom_core`

## Requirements
- R1: After reset, `sdo_oe_o` and `busy_o` are both low.
- R2: A chip select that is already low when reset ends starts no command. A command starts only after chip select has been seen high and then falls.
- R3: Opcode 0x03 reads and opcode 0x02 writes. Each is followed by a 16-bit address. Opcode, address and data all travel MSB first. SDI is sampled on rising SCK, and SDO changes after falling SCK. This holds in both SCK idle levels (mode 0 and mode 3).
- R4: Address bits at or above log2(MEM_BYTES) are ignored.
- R5: A read streams consecutive bytes for as long as SCK runs. After the top address the read continues at address 0.
- R6: Write bytes that run past the end of a PAGE_BYTES-aligned page wrap to the start of that same page.
- R7: A write commits only if chip select rises after at least one complete data byte, with no partial byte pending. Otherwise `busy_o` stays low and the array is unchanged.
- R8: A write commits only if `wr_permit_i` is high at the chip-select rise.
- R9: After a commit, `busy_o` stays high for exactly WRITE_CYCLES clock cycles. Array writes happen only while it is high.
- R10: While `busy_o` is high, READ and WRITE commands are ignored. SDO stays disabled and nothing is written.
- R11: Opcode 0x05 streams the byte {prot_status_i[6:0], busy} repeatedly. The busy bit is bit 0, and it is taken from the live busy state at each byte load. This command is also served while busy.
- R12: Opcodes 0x06, 0x04 and 0x01, and any unknown opcode, keep SDO disabled until chip select rises and leave the array unchanged.
- R13: SDO is disabled within a few clocks of a chip-select rise and stays disabled while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock |
| csn_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data into the target |
| sdo_o | output | 1 | Serial data out of the target |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` (low = high impedance) |
| wr_permit_i | input | 1 | Commit permission from the protection unit |
| prot_status_i | input | 7 | Upper status bits supplied by the protection unit |
| busy_o | output | 1 | High during the self-timed write |

## Verification
The busy timer can expire in the same clock cycle that a status byte is reloaded for shifting. The bench provokes this by starting a long status read right after a commit. It streams enough status bytes to span the whole busy interval, so that one byte reload lands near the expiry. The stream is judged correct only if three things hold:
- The upper seven bits of every byte match `prot_status_i`.
- The busy bit starts at 1, ends at 0, and never returns to 1 after the first 0.
- No byte is lost or shifted at the changeover.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_STATUS,
        ST_SINK
    } ee_state_t;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_RDSR  = 8'h05;

    localparam int ADDR_BITS = 16;

endpackage

// File: rtl/ee_pin_sync.sv
module ee_pin_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    assign pin_o = sync_q;
endmodule

// File: rtl/ee_write_timer.sv
module ee_write_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start_i) begin
            left_q <= CW'(CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy_o = (left_q != '0);
endmodule

// File: rtl/ee_page_stager.sv
module ee_page_stager #(
    parameter int PAGE_BYTES = 16,
    parameter int AW         = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear_i,
    input  logic                         load_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] load_off_i,
    input  logic [7:0]                   load_data_i,
    input  logic                         commit_i,
    input  logic [AW-$clog2(PAGE_BYTES)-1:0] commit_page_i,
    output logic                         mem_we_o,
    output logic [AW-1:0]                mem_waddr_o,
    output logic [7:0]                   mem_wdata_o
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int BW = AW - PW;

    logic [7:0]            stage_mem [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] filled_q;
    logic                  walking_q;
    logic [PW-1:0]         walk_idx_q;
    logic [BW-1:0]         walk_page_q;

    always_ff @(posedge clk) begin
        if (load_i) begin
            stage_mem[load_off_i] <= load_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filled_q <= '0;
        end else if (clear_i) begin
            filled_q <= '0;
        end else if (load_i) begin
            filled_q[load_off_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walking_q   <= 1'b0;
            walk_idx_q  <= '0;
            walk_page_q <= '0;
        end else if (commit_i) begin
            walking_q   <= 1'b1;
            walk_idx_q  <= '0;
            walk_page_q <= commit_page_i;
        end else if (walking_q) begin
            walk_idx_q <= walk_idx_q + 1'b1;
            if (walk_idx_q == PW'(PAGE_BYTES - 1)) begin
                walking_q <= 1'b0;
            end
        end
    end

    assign mem_we_o    = walking_q && filled_q[walk_idx_q];
    assign mem_waddr_o = {walk_page_q, walk_idx_q};
    assign mem_wdata_o = stage_mem[walk_idx_q];
endmodule

// File: rtl/ee_byte_array.sv
module ee_byte_array #(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] waddr_i,
    input  logic [7:0]               wdata_i,
    input  logic [$clog2(DEPTH)-1:0] raddr_i,
    output logic [7:0]               rdata_o
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/spi_eeprom_core.sv
module spi_eeprom_core
    import eeprom_spi_pkg::*;
#(
    parameter int MEM_BYTES    = 1024,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       csn_i,
    input  logic       sdi_i,
    output logic       sdo_o,
    output logic       sdo_oe_o,
    input  logic       wr_permit_i,
    input  logic [6:0] prot_status_i,
    output logic       busy_o
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int BW = AW - PW;

    // Pin synchronisation and edge detection
    logic [2:0] pins_s;
    logic       csn_s, sck_s, sdi_s;
    logic       csn_q, sck_q;
    logic       cs_fall, cs_rise, sck_rise, sck_fall;

    ee_pin_sync #(.WIDTH(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({csn_i, sck_i, sdi_i}),
        .pin_o (pins_s)
    );

    assign csn_s = pins_s[2];
    assign sck_s = pins_s[1];
    assign sdi_s = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_q <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            csn_q <= csn_s;
            sck_q <= sck_s;
        end
    end

    assign cs_fall  =  csn_q && !csn_s;
    assign cs_rise  = !csn_q &&  csn_s;
    assign sck_rise = !sck_q &&  sck_s;
    assign sck_fall =  sck_q && !sck_s;

    // Datapath registers
    ee_state_t     state_q, state_d;
    logic [2:0]    bit_cnt_q;
    logic [3:0]    addr_bits_q;
    logic [2:0]    out_cnt_q;
    logic [6:0]    shin_q;
    logic [AW-1:0] addr_sh_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    tx_q;
    logic          sdo_q;
    logic          is_write_q;
    logic          got_byte_q;
    logic [PW-1:0] wr_off_q;
    logic [BW-1:0] page_q;

    logic [7:0]    in_byte;
    logic [AW-1:0] addr_full;
    logic [7:0]    status_byte;
    logic          byte_done;
    logic          addr_done;
    logic          out_byte_done;

    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [7:0]    arr_wdata;
    logic [AW-1:0] arr_raddr;
    logic [7:0]    arr_rdata;

    logic          stage_clear;
    logic          stage_load;
    logic          commit_go;
    logic          busy;
    logic          rd_active;

    assign in_byte       = {shin_q, sdi_s};
    assign addr_full     = {addr_sh_q[AW-2:0], sdi_s};
    assign status_byte   = {prot_status_i, busy};
    assign byte_done     = sck_rise && (bit_cnt_q == 3'd7);
    assign addr_done     = sck_rise && (addr_bits_q == 4'd15);
    assign out_byte_done = sck_fall && (out_cnt_q == 3'd7);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_rise) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_fall) state_d = ST_OPCODE;
                end
                ST_OPCODE: begin
                    if (byte_done) begin
                        case (in_byte)
                            OP_READ, OP_WRITE: state_d = busy ? ST_SINK : ST_ADDR;
                            OP_RDSR:           state_d = ST_STATUS;
                            default:           state_d = ST_SINK;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (addr_done) state_d = is_write_q ? ST_WR_DATA : ST_RD_DATA;
                end
                ST_RD_DATA, ST_WR_DATA, ST_STATUS, ST_SINK: begin
                    state_d = state_q;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Sequencing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            addr_bits_q <= '0;
            out_cnt_q   <= '0;
            shin_q      <= '0;
            addr_sh_q   <= '0;
            addr_q      <= '0;
            tx_q        <= '0;
            sdo_q       <= 1'b0;
            is_write_q  <= 1'b0;
            got_byte_q  <= 1'b0;
            wr_off_q    <= '0;
            page_q      <= '0;
        end else if (cs_rise) begin
            bit_cnt_q   <= '0;
            addr_bits_q <= '0;
            got_byte_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    bit_cnt_q   <= '0;
                    addr_bits_q <= '0;
                end
                ST_OPCODE: begin
                    if (sck_rise) begin
                        shin_q    <= in_byte[6:0];
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                    if (byte_done) begin
                        is_write_q  <= (in_byte == OP_WRITE);
                        got_byte_q  <= 1'b0;
                        addr_bits_q <= '0;
                        out_cnt_q   <= '0;
                        tx_q        <= status_byte;
                    end
                end
                ST_ADDR: begin
                    if (sck_rise) begin
                        addr_sh_q   <= addr_full;
                        addr_bits_q <= addr_bits_q + 1'b1;
                    end
                    if (addr_done) begin
                        bit_cnt_q <= '0;
                        out_cnt_q <= '0;
                        addr_q    <= addr_full + 1'b1;
                        tx_q      <= arr_rdata;
                        page_q    <= addr_full[AW-1:PW];
                        wr_off_q  <= addr_full[PW-1:0];
                    end
                end
                ST_RD_DATA, ST_STATUS: begin
                    if (sck_fall) begin
                        sdo_q     <= tx_q[7];
                        tx_q      <= {tx_q[6:0], 1'b0};
                        out_cnt_q <= out_cnt_q + 1'b1;
                    end
                    if (out_byte_done) begin
                        if (state_q == ST_RD_DATA) begin
                            tx_q   <= arr_rdata;
                            addr_q <= addr_q + 1'b1;
                        end else begin
                            tx_q <= status_byte;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (sck_rise) begin
                        shin_q    <= in_byte[6:0];
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                    if (byte_done) begin
                        wr_off_q   <= wr_off_q + 1'b1;
                        got_byte_q <= 1'b1;
                    end
                end
                ST_SINK: begin
                    bit_cnt_q <= '0;
                end
                default: bit_cnt_q <= '0;
            endcase
        end
    end

    // Control pulses into the stager and the timer
    assign stage_clear = (state_q == ST_OPCODE) && byte_done && (in_byte == OP_WRITE) && !busy;
    assign stage_load  = (state_q == ST_WR_DATA) && byte_done && !cs_rise;
    assign commit_go   = cs_rise && (state_q == ST_WR_DATA) && (bit_cnt_q == 3'd0)
                         && got_byte_q && wr_permit_i;
    assign arr_raddr   = (state_q == ST_ADDR) ? addr_full : addr_q;

    ee_page_stager #(.PAGE_BYTES(PAGE_BYTES), .AW(AW)) u_stager (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (stage_clear),
        .load_i        (stage_load),
        .load_off_i    (wr_off_q),
        .load_data_i   (in_byte),
        .commit_i      (commit_go),
        .commit_page_i (page_q),
        .mem_we_o      (arr_we),
        .mem_waddr_o   (arr_waddr),
        .mem_wdata_o   (arr_wdata)
    );

    ee_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit_go),
        .busy_o  (busy)
    );

    ee_byte_array #(.DEPTH(MEM_BYTES)) u_array (
        .clk     (clk),
        .we_i    (arr_we),
        .waddr_i (arr_waddr),
        .wdata_i (arr_wdata),
        .raddr_i (arr_raddr),
        .rdata_o (arr_rdata)
    );

    // Outputs
    always_comb begin
        rd_active = (state_q == ST_RD_DATA);
        sdo_oe_o  = rd_active || (state_q == ST_STATUS);
        sdo_o     = sdo_oe_o ? sdo_q : 1'b0;
        busy_o    = busy;
    end
endmodule

// File: rtl/spi_eeprom_checker.sv
module spi_eeprom_checker #(
    parameter int WRITE_CYCLES = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic cs_rise,
    input logic sdo_oe_o,
    input logic busy_o,
    input logic wr_permit_i,
    input logic arr_we,
    input logic rd_active
);
    int busy_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_len_q <= 0;
        else if (busy_o) busy_len_q <= busy_len_q + 1;
        else             busy_len_q <= 0;
    end

    // R13
    sdo_off_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !sdo_oe_o);

    // R9
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len_q == WRITE_CYCLES));

    // R8
    commit_permitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(wr_permit_i));

    // R9
    array_write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy_o);

    // R10
    no_read_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !rd_active);
endmodule

bind spi_eeprom_core spi_eeprom_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_rise     (cs_rise),
    .sdo_oe_o    (sdo_oe_o),
    .busy_o      (busy_o),
    .wr_permit_i (wr_permit_i),
    .arr_we      (arr_we),
    .rd_active   (rd_active)
);

// File: tb/tb_spi_eeprom_core.sv
module tb_spi_eeprom_core;
    localparam int MEM_BYTES    = 1024;
    localparam int PAGE_BYTES   = 16;
    localparam int WRITE_CYCLES = 2000;
    localparam int HALF         = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       csn = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo, sdo_oe, busy;
    logic       permit = 1'b1;
    logic [6:0] prot = 7'h53;

    int   vec = 0;
    int   miss = 0;
    int   last_busy = 0;
    logic oe_seen = 1'b0;
    logic [7:0] wbuf [32];
    logic [7:0] rbuf [32];

    always #5 clk = ~clk;

    spi_eeprom_core #(
        .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .wr_permit_i(permit),
        .prot_status_i(prot), .busy_o(busy)
    );

    always @(negedge clk) if (sdo_oe) oe_seen = 1'b1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (!ok) begin
            miss++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic spi_begin(input bit mode3);
        sck = mode3;
        tick(HALF);
        csn = 1'b0;
        oe_seen = 1'b0;
        tick(HALF);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            sck = 1'b0;
            sdi = tx[i];
            tick(HALF);
            rx[i] = sdo;
            sck = 1'b1;
            tick(HALF);
        end
    endtask

    task automatic spi_end(input bit mode3);
        tick(HALF);
        if (!mode3) begin
            sck = 1'b0;
            tick(HALF);
        end
        csn = 1'b1;
    endtask

    task automatic measure_busy();
        int c = 0;
        for (int k = 0; k < WRITE_CYCLES * 2 + 100; k++) begin
            @(negedge clk);
            if (busy) c++;
            else if (c > 0 || k > 60) break;
        end
        last_busy = c;
    endtask

    task automatic write_page(input logic [15:0] a, input int n, input bit mode3, input bit wait_done);
        logic [7:0] rx;
        spi_begin(mode3);
        spi_bits(8'h02, 8, rx);
        spi_bits(a[15:8], 8, rx);
        spi_bits(a[7:0], 8, rx);
        for (int i = 0; i < n; i++) spi_bits(wbuf[i], 8, rx);
        spi_end(mode3);
        if (wait_done) measure_busy();
    endtask

    task automatic read_seq(input logic [15:0] a, input int n, input bit mode3, input string tag);
        logic [7:0] rx;
        spi_begin(mode3);
        spi_bits(8'h03, 8, rx);
        spi_bits(a[15:8], 8, rx);
        spi_bits(a[7:0], 8, rx);
        for (int i = 0; i < n; i++) spi_bits(8'h00, 8, rbuf[i]);
        spi_end(mode3);
        tick(6);
        chk(!sdo_oe, {tag, " R13 sdo disabled after deselect"}, sdo_oe, 0);
    endtask

    task automatic t_reset();
        logic [7:0] rx;
        chk(sdo_oe == 1'b0, "R1 sdo_oe after reset", sdo_oe, 0);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        oe_seen = 1'b0;
        spi_bits(8'h03, 8, rx);
        spi_bits(8'h00, 8, rx);
        spi_bits(8'h00, 8, rx);
        spi_bits(8'h00, 8, rx);
        chk(oe_seen == 1'b0, "R2 command ignored without prior deselect", oe_seen, 0);
        sck = 1'b0;
        tick(HALF);
        csn = 1'b1;
        tick(HALF * 2);
    endtask

    task automatic t_write_read();
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3; wbuf[2] = 8'h81;
        write_page(16'hFC10, 3, 1'b0, 1'b1);
        chk(last_busy == WRITE_CYCLES, "R9 busy length", last_busy, WRITE_CYCLES);
        read_seq(16'h0010, 3, 1'b1, "R3");
        for (int i = 0; i < 3; i++)
            chk(rbuf[i] == wbuf[i], "R3 mode3 readback", rbuf[i], wbuf[i]);
        read_seq(16'h0410, 3, 1'b0, "R4");
        for (int i = 0; i < 3; i++)
            chk(rbuf[i] == wbuf[i], "R4 upper address bits ignored", rbuf[i], wbuf[i]);
    endtask

    task automatic t_rollover();
        wbuf[0] = 8'h11;
        write_page(16'h03FF, 1, 1'b1, 1'b1);
        wbuf[0] = 8'h22; wbuf[1] = 8'h33;
        write_page(16'h0000, 2, 1'b0, 1'b1);
        read_seq(16'h03FF, 3, 1'b0, "R5");
        chk(rbuf[0] == 8'h11, "R5 top byte", rbuf[0], 8'h11);
        chk(rbuf[1] == 8'h22, "R5 rollover to zero", rbuf[1], 8'h22);
        chk(rbuf[2] == 8'h33, "R5 increment after rollover", rbuf[2], 8'h33);
    endtask

    task automatic t_page_wrap();
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
        write_page(16'h002E, 4, 1'b0, 1'b1);
        read_seq(16'h0020, 2, 1'b1, "R6");
        chk(rbuf[0] == 8'hC3, "R6 wrapped byte at page start", rbuf[0], 8'hC3);
        chk(rbuf[1] == 8'hD4, "R6 wrapped byte at page start+1", rbuf[1], 8'hD4);
        read_seq(16'h002E, 2, 1'b0, "R6");
        chk(rbuf[0] == 8'hA1 && rbuf[1] == 8'hB2, "R6 bytes before wrap", {rbuf[0], rbuf[1]}, 16'hA1B2);
    endtask

    task automatic t_abort();
        logic [7:0] rx;
        wbuf[0] = 8'h77;
        write_page(16'h0100, 1, 1'b0, 1'b1);
        spi_begin(1'b0);
        spi_bits(8'h02, 8, rx); spi_bits(8'h01, 8, rx); spi_bits(8'h00, 8, rx);
        spi_bits(8'h99, 8, rx); spi_bits(8'hEE, 4, rx);
        spi_end(1'b0);
        measure_busy();
        chk(last_busy == 0, "R7 partial byte: no busy", last_busy, 0);
        spi_begin(1'b1);
        spi_bits(8'h02, 8, rx); spi_bits(8'h01, 8, rx); spi_bits(8'h00, 8, rx);
        spi_end(1'b1);
        measure_busy();
        chk(last_busy == 0, "R7 no data byte: no busy", last_busy, 0);
        read_seq(16'h0100, 1, 1'b0, "R7");
        chk(rbuf[0] == 8'h77, "R7 array unchanged after abort", rbuf[0], 8'h77);
    endtask

    task automatic t_permit();
        permit = 1'b0;
        wbuf[0] = 8'h55;
        write_page(16'h0100, 1, 1'b0, 1'b1);
        permit = 1'b1;
        chk(last_busy == 0, "R8 no busy without permit", last_busy, 0);
        read_seq(16'h0100, 1, 1'b1, "R8");
        chk(rbuf[0] == 8'h77, "R8 array unchanged without permit", rbuf[0], 8'h77);
    endtask

    task automatic t_busy_block();
        wbuf[0] = 8'h3C;
        write_page(16'h0200, 1, 1'b0, 1'b0);
        tick(8);
        chk(busy == 1'b1, "R10 busy after commit", busy, 1);
        read_seq(16'h0200, 1, 1'b0, "R10");
        chk(oe_seen == 1'b0, "R10 read during busy keeps sdo off", oe_seen, 0);
        wbuf[0] = 8'hFF;
        write_page(16'h0200, 1, 1'b1, 1'b0);
        chk(busy == 1'b1, "R10 still busy after ignored write", busy, 1);
        while (busy) tick(1);
        measure_busy();
        chk(last_busy == 0, "R10 ignored write starts no timer", last_busy, 0);
        read_seq(16'h0200, 1, 1'b1, "R10");
        chk(rbuf[0] == 8'h3C, "R10 write during busy ignored", rbuf[0], 8'h3C);
    endtask

    task automatic t_status();
        logic [7:0] rx;
        logic first_b0, last_b0, saw_zero, relapse, upper_ok;
        wbuf[0] = 8'h42;
        write_page(16'h0180, 1, 1'b0, 1'b0);
        spi_begin(1'b0);
        spi_bits(8'h05, 8, rx);
        saw_zero = 1'b0; relapse = 1'b0; upper_ok = 1'b1; first_b0 = 1'b0; last_b0 = 1'b1;
        for (int i = 0; i < 18; i++) begin
            spi_bits(8'h00, 8, rx);
            if (rx[7:1] != prot) upper_ok = 1'b0;
            if (i == 0) first_b0 = rx[0];
            if (saw_zero && rx[0]) relapse = 1'b1;
            if (!rx[0]) saw_zero = 1'b1;
            last_b0 = rx[0];
        end
        spi_end(1'b0);
        tick(6);
        chk(upper_ok, "R11 upper status bits", upper_ok, 1);
        chk(first_b0 == 1'b1, "R11 busy bit set early", first_b0, 1);
        chk(last_b0 == 1'b0, "R11 busy bit clear late", last_b0, 0);
        chk(!relapse, "R11 busy bit monotonic", relapse, 0);
        chk(!sdo_oe, "R13 sdo disabled after status read", sdo_oe, 0);
        while (busy) tick(1);
    endtask

    task automatic t_ignored_ops();
        logic [7:0] rx;
        logic [7:0] ops [4];
        ops[0] = 8'h06; ops[1] = 8'h04; ops[2] = 8'h01; ops[3] = 8'hA5;
        for (int k = 0; k < 4; k++) begin
            spi_begin(k[0]);
            spi_bits(ops[k], 8, rx);
            spi_bits(8'h01, 8, rx); spi_bits(8'h00, 8, rx); spi_bits(8'hCC, 8, rx);
            spi_end(k[0]);
            measure_busy();
            chk(oe_seen == 1'b0, "R12 sdo stays off", ops[k], 0);
            chk(last_busy == 0, "R12 no busy", last_busy, 0);
        end
        read_seq(16'h0100, 1, 1'b0, "R12");
        chk(rbuf[0] == 8'h77, "R12 array unchanged", rbuf[0], 8'h77);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end

    initial begin : main
        tick(10);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_write_read();
        t_rollover();
        t_page_wrap();
        t_abort();
        t_permit();
        t_busy_block();
        t_status();
        t_ignored_ops();
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end
endmodule